// File: doc/BRIEF.md
# Profile-Selectable DDS Phase Core

This block is the digital heart of a direct digital synthesizer. On every system clock it adds a 32-bit frequency tuning word to a phase accumulator. It adds a 14-bit phase offset to the top of that phase and turns the result into a 10-bit offset-binary sine code for a DAC. A fractional modulus stage can add an extra phase LSB on selected cycles, which gives step sizes that are not a binary fraction of the full circle.

Eight profiles come from the surrounding register file. Each profile carries one 32-bit word and a kind bit. The kind bit says whether the word is a tuning word or a phase offset. The quantity the profile does not carry is taken from a base input. A 3-bit select input picks the profile. All of these inputs are staging values. The core copies them into its active registers only in a cycle where the update strobe is sampled high. The matched-latency switch sets whether a phase change takes the same number of clocks to reach the output as a frequency change, or one clock fewer.

Top module: `dds_profile_core`

## Requirements
- R1: While `rst` is high, `dac_code` is 512 (mid-scale).
- R2: For a 14-bit output phase p, let q = p[13:12] and i = p[11:4]. If q[0] is 1, i is replaced by 255−i. Let m = round(511·sin((2i+1)·π/1024)). Then `dac_code` is 512+m when q[1] is 0 and 511−m when q[1] is 1, within 1 LSB. Bits p[3:0] do not affect the code.
- R3: When the selected profile's kind bit is 1, the low 14 bits of its word become the phase offset and `base_ftw` becomes the tuning word. When the kind bit is 0, the word becomes the tuning word and `base_pow` becomes the phase offset. Profile k occupies `prof_words[32k+31:32k]` and `prof_kind[k]`.
- R4: Changes to `prof_sel`, the profile words, the base words or the modulus inputs have no effect on `dac_code` until `io_update` is sampled high.
- R5: The accumulator starts at 0 after reset. Every clock it adds the active tuning word plus the modulus carry, modulo 2^32. The output phase p is the accumulator's top 14 bits plus the phase offset, modulo 2^14.
- R6: If the update strobe is sampled at clock edge k and carries a new tuning word, the first output affected is the one registered at edge k+11. This holds in both latency modes.
- R7: A new phase offset applied at edge k first shows at edge k+11 when `match_latency` is 1, and at edge k+10 when it is 0. The `match_latency` input is a static setting.
- R8: When modulus mode is active, an auxiliary register adds `mod_step` each clock. When the sum is at least `mod_base`, it subtracts `mod_base` and adds 1 to the accumulator in that same clock. With `mod_step` < `mod_base`, the auxiliary value stays below `mod_base`.
- R9: When modulus mode is inactive, the auxiliary register holds 0 and no carry is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| io_update | input | 1 | Copies staged settings into the active registers |
| prof_sel | input | 3 | Profile chosen at the next update |
| prof_kind | input | 8 | Per-profile kind: 1 = phase offset word, 0 = tuning word |
| prof_words | input | 256 | Eight 32-bit profile words, profile k at bits 32k+31:32k |
| base_ftw | input | 32 | Tuning word used with phase-kind profiles |
| base_pow | input | 14 | Phase offset used with frequency-kind profiles |
| mod_enable | input | 1 | Enables fractional modulus stepping |
| mod_step | input | 32 | Auxiliary step added each clock |
| mod_base | input | 32 | Auxiliary modulus |
| match_latency | input | 1 | 1: phase path delayed to equal the frequency path |
| dac_code | output | 10 | Offset-binary sine amplitude code |

## Verification
Some properties are checked on every cycle. The active settings hold still unless the update strobe was sampled. The auxiliary modulus register stays below its modulus while modulus mode runs, and it stays at zero while the mode is off. The output leaves reset at mid-scale. The scenarios cover what only an end-to-end comparison can show: the exact clock counts of the frequency and phase paths in both latency modes, the sine codes at quadrant edges and mid-quadrant, profile kind routing, and accumulated phase with and without fractional carries, all compared against an independent real-valued model.

// File: rtl/dds_pkg.sv
package dds_pkg;

  typedef enum logic {
    KIND_FREQ  = 1'b0,
    KIND_PHASE = 1'b1
  } prof_kind_e;

  // pi scaled by 2^30
  localparam longint PI_Q30 = 64'sd3373259426;

  // Quarter-wave magnitude of entry idx in a table of 2^idx_w entries,
  // sampled at half-step centres, scaled to amp. Fixed-point Taylor series.
  function automatic int quarter_sine_mag(input int idx, input int idx_w, input int amp);
    longint x;
    longint x2;
    longint term;
    longint sum;
    x    = (longint'(2 * idx + 1) * PI_Q30) / (longint'(4) << idx_w);
    x2   = (x * x) >>> 30;
    term = x;
    sum  = x;
    for (int k = 1; k <= 6; k++) begin
      term = -((term * x2) >>> 30) / longint'((2 * k) * (2 * k + 1));
      sum  = sum + term;
    end
    return int'((sum * longint'(amp) + (64'sd1 <<< 29)) >>> 30);
  endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] ftw,
  input  logic             mod_on,
  input  logic [ACC_W-1:0] mod_a,
  input  logic [ACC_W-1:0] mod_b,
  output logic [PH_W-1:0]  phase_top,
  output logic [ACC_W-1:0] aux_q
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   aux_sum;
  logic [ACC_W:0]   aux_wrap;
  logic             carry;
  logic [ACC_W-1:0] aux_d;

  always_comb begin
    aux_sum  = {1'b0, aux_q} + {1'b0, mod_a};
    aux_wrap = aux_sum - {1'b0, mod_b};
    carry    = mod_on && (aux_sum >= {1'b0, mod_b});
    if (!mod_on)    aux_d = '0;
    else if (carry) aux_d = aux_wrap[ACC_W-1:0];
    else            aux_d = aux_sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      aux_q <= '0;
    end else begin
      acc_q <= acc_q + ftw + {{(ACC_W-1){1'b0}}, carry};
      aux_q <= aux_d;
    end
  end

  assign phase_top = acc_q[ACC_W-1 -: PH_W];

endmodule

// File: rtl/dds_align.sv
module dds_align #(
  parameter int PH_W    = 14,
  parameter int ACC_DLY = 6,
  parameter int OUT_PW  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PH_W-1:0]   acc_top,
  input  logic [PH_W-1:0]   pow,
  input  logic              match_on,
  output logic [OUT_PW-1:0] phase_q
);

  localparam int POW_DLY = ACC_DLY + 1;
  localparam int DROP    = PH_W - OUT_PW;

  logic [PH_W-1:0] acc_pipe [ACC_DLY];
  logic [PH_W-1:0] pow_pipe [POW_DLY];
  logic [PH_W-1:0] pow_tap;
  logic [PH_W-1:0] sum_full;
  logic            unused_lsbs;

  genvar g;
  generate
    for (g = 0; g < ACC_DLY; g++) begin : g_acc
      always_ff @(posedge clk) begin
        if (rst)         acc_pipe[g] <= '0;
        else if (g == 0) acc_pipe[g] <= acc_top;
        else             acc_pipe[g] <= acc_pipe[(g == 0) ? 0 : g - 1];
      end
    end
    for (g = 0; g < POW_DLY; g++) begin : g_pow
      always_ff @(posedge clk) begin
        if (rst)         pow_pipe[g] <= '0;
        else if (g == 0) pow_pipe[g] <= pow;
        else             pow_pipe[g] <= pow_pipe[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  always_comb begin
    pow_tap  = match_on ? pow_pipe[POW_DLY-1] : pow_pipe[POW_DLY-2];
    sum_full = acc_pipe[ACC_DLY-1] + pow_tap;
  end

  assign unused_lsbs = ^sum_full[DROP-1:0];

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= sum_full[PH_W-1 -: OUT_PW];
  end

endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
  parameter int IDX_W = 8,
  parameter int OUT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W+1:0] phase,
  output logic [OUT_W-1:0] code_q
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int MAG_W = OUT_W - 1;
  localparam int AMP   = (1 << MAG_W) - 1;

  logic [MAG_W-1:0] rom [DEPTH];
  logic [IDX_W-1:0] idx_q;
  logic             neg_q1;
  logic             neg_q2;
  logic [MAG_W-1:0] mag_q;

  initial begin
    for (int i = 0; i < DEPTH; i++)
      rom[i] = MAG_W'(dds_pkg::quarter_sine_mag(i, IDX_W, AMP));
  end

  // stage 1: quadrant fold
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      neg_q1 <= 1'b0;
    end else begin
      idx_q  <= phase[IDX_W] ? ~phase[IDX_W-1:0] : phase[IDX_W-1:0];
      neg_q1 <= phase[IDX_W+1];
    end
  end

  // stage 2: registered ROM read
  always_ff @(posedge clk) begin
    if (rst) begin
      mag_q  <= '0;
      neg_q2 <= 1'b0;
    end else begin
      mag_q  <= rom[idx_q];
      neg_q2 <= neg_q1;
    end
  end

  // stage 3: offset-binary sign
  always_ff @(posedge clk) begin
    if (rst)         code_q <= {1'b1, {MAG_W{1'b0}}};
    else if (neg_q2) code_q <= {1'b0, ~mag_q};
    else             code_q <= {1'b1, mag_q};
  end

endmodule

// File: rtl/dds_profile_core.sv
module dds_profile_core #(
  parameter int NPROF        = 8,
  parameter int FTW_W        = 32,
  parameter int POW_W        = 14,
  parameter int IDX_W        = 8,
  parameter int OUT_W        = 10,
  parameter int FREQ_LATENCY = 11
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     io_update,
  input  logic [$clog2(NPROF)-1:0] prof_sel,
  input  logic [NPROF-1:0]         prof_kind,
  input  logic [NPROF*FTW_W-1:0]   prof_words,
  input  logic [FTW_W-1:0]         base_ftw,
  input  logic [POW_W-1:0]         base_pow,
  input  logic                     mod_enable,
  input  logic [FTW_W-1:0]         mod_step,
  input  logic [FTW_W-1:0]         mod_base,
  input  logic                     match_latency,
  output logic [OUT_W-1:0]         dac_code
);

  import dds_pkg::*;

  localparam int ACC_DLY = FREQ_LATENCY - 5;
  localparam int LUT_PW  = IDX_W + 2;

  logic [FTW_W-1:0]  sel_word;
  prof_kind_e        sel_kind;
  logic [FTW_W-1:0]  ftw_act;
  logic [POW_W-1:0]  pow_act;
  logic              mod_on_act;
  logic [FTW_W-1:0]  mod_a_act;
  logic [FTW_W-1:0]  mod_b_act;
  logic [POW_W-1:0]  acc_top;
  logic [FTW_W-1:0]  aux_val;
  logic [LUT_PW-1:0] lut_phase;

  always_comb begin
    sel_word = prof_words[prof_sel*FTW_W +: FTW_W];
    sel_kind = prof_kind_e'(prof_kind[prof_sel]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ftw_act    <= '0;
      pow_act    <= '0;
      mod_on_act <= 1'b0;
      mod_a_act  <= '0;
      mod_b_act  <= '0;
    end else if (io_update) begin
      if (sel_kind == KIND_PHASE) begin
        ftw_act <= base_ftw;
        pow_act <= sel_word[POW_W-1:0];
      end else begin
        ftw_act <= sel_word;
        pow_act <= base_pow;
      end
      mod_on_act <= mod_enable;
      mod_a_act  <= mod_step;
      mod_b_act  <= mod_base;
    end
  end

  dds_phase_acc #(.ACC_W(FTW_W), .PH_W(POW_W)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .ftw       (ftw_act),
    .mod_on    (mod_on_act),
    .mod_a     (mod_a_act),
    .mod_b     (mod_b_act),
    .phase_top (acc_top),
    .aux_q     (aux_val)
  );

  dds_align #(.PH_W(POW_W), .ACC_DLY(ACC_DLY), .OUT_PW(LUT_PW)) u_align (
    .clk      (clk),
    .rst      (rst),
    .acc_top  (acc_top),
    .pow      (pow_act),
    .match_on (match_latency),
    .phase_q  (lut_phase)
  );

  dds_sine_rom #(.IDX_W(IDX_W), .OUT_W(OUT_W)) u_sine (
    .clk    (clk),
    .rst    (rst),
    .phase  (lut_phase),
    .code_q (dac_code)
  );

endmodule

// File: rtl/dds_profile_core_chk.sv
module dds_profile_core_chk #(
  parameter int FTW_W = 32,
  parameter int POW_W = 14,
  parameter int OUT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             io_update,
  input logic [FTW_W-1:0] ftw_act,
  input logic [POW_W-1:0] pow_act,
  input logic             mod_on,
  input logic [FTW_W-1:0] mod_a,
  input logic [FTW_W-1:0] mod_b,
  input logic [FTW_W-1:0] aux_q,
  input logic [OUT_W-1:0] dac_code
);

  localparam logic [OUT_W-1:0] MID = OUT_W'(1 << (OUT_W - 1));

  assert_mid_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> dac_code == MID);

  assert_hold_without_update_R4: assert property (@(posedge clk) disable iff (rst)
    !io_update |=> ($stable(ftw_act) && $stable(pow_act) && $stable(mod_on)
                    && $stable(mod_a) && $stable(mod_b)));

  assert_aux_below_base_R8: assert property (@(posedge clk) disable iff (rst)
    (mod_on && !io_update && (mod_a < mod_b) && (aux_q < mod_b)) |=> aux_q < mod_b);

  assert_aux_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!mod_on && !io_update) |=> aux_q == '0);

endmodule

bind dds_profile_core dds_profile_core_chk #(
  .FTW_W (FTW_W),
  .POW_W (POW_W),
  .OUT_W (OUT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .io_update (io_update),
  .ftw_act   (ftw_act),
  .pow_act   (pow_act),
  .mod_on    (mod_on_act),
  .mod_a     (mod_a_act),
  .mod_b     (mod_b_act),
  .aux_q     (aux_val),
  .dac_code  (dac_code)
);

// File: tb/tb_dds_profile_core.sv
module tb_dds_profile_core;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         io_update = 1'b0;
  logic [2:0]   prof_sel = '0;
  logic [7:0]   prof_kind = '0;
  logic [255:0] prof_words = '0;
  logic [31:0]  base_ftw = '0;
  logic [13:0]  base_pow = '0;
  logic         mod_enable = 1'b0;
  logic [31:0]  mod_step = '0;
  logic [31:0]  mod_base = '0;
  logic         match_latency = 1'b1;
  logic [9:0]   dac_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dds_profile_core dut (
    .clk(clk), .rst(rst), .io_update(io_update), .prof_sel(prof_sel),
    .prof_kind(prof_kind), .prof_words(prof_words), .base_ftw(base_ftw),
    .base_pow(base_pow), .mod_enable(mod_enable), .mod_step(mod_step),
    .mod_base(mod_base), .match_latency(match_latency), .dac_code(dac_code)
  );

  // {profile select, expected code}; profiles set up in the table test
  localparam logic [12:0] VEC [8] = '{
    {3'd0, 10'd514}, {3'd1, 10'd1023}, {3'd2, 10'd509}, {3'd3, 10'd0},
    {3'd4, 10'd509}, {3'd5, 10'd874},  {3'd6, 10'd1023}, {3'd7, 10'd1023}
  };

  function automatic int code_of(input int ph);
    int  q;
    int  i;
    int  mag;
    real ang;
    q = (ph >> 12) & 3;
    i = (ph >> 4) & 255;
    if ((q & 1) != 0) i = 255 - i;
    ang = (2.0 * i + 1.0) * 3.14159265358979 / 1024.0;
    mag = int'($floor(511.0 * $sin(ang) + 0.5));
    return ((q & 2) != 0) ? 511 - mag : 512 + mag;
  endfunction

  function automatic int model_code(input int steps, input logic [31:0] ftw,
                                    input bit mod_on, input logic [31:0] a,
                                    input logic [31:0] b, input logic [13:0] pow);
    logic [31:0] acc;
    logic [31:0] aux;
    logic [32:0] s;
    logic        c;
    acc = '0;
    aux = '0;
    for (int n = 0; n < steps; n++) begin
      s   = {1'b0, aux} + {1'b0, a};
      c   = mod_on && (s >= {1'b0, b});
      aux = !mod_on ? 32'd0 : (c ? 32'(s - {1'b0, b}) : s[31:0]);
      acc = acc + ftw + {31'd0, c};
    end
    return code_of(int'(14'(acc[31:18] + pow)));
  endfunction

  task automatic chk(input string tag, input int act, input int exp, input int tol);
    checks++;
    if (act - exp > tol || exp - act > tol) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    io_update = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset mid-scale", int'(dac_code), 512, 0);
    rst = 1'b0;
  endtask

  task automatic do_update(input logic [2:0] sel);
    @(negedge clk);
    prof_sel  = sel;
    io_update = 1'b1;
    @(negedge clk);
    io_update = 1'b0;
  endtask

  task automatic set_word(input int k, input logic [31:0] w, input bit is_phase);
    prof_words[k*32 +: 32] = w;
    prof_kind[k] = is_phase;
  endtask

  task automatic mod_run(input string tag, input bit on, input logic [31:0] a,
                         input logic [31:0] b);
    do_reset();
    set_word(6, 32'h003F_FFFF, 1'b0);
    base_pow   = '0;
    mod_enable = on;
    mod_step   = a;
    mod_base   = b;
    do_update(3'd6);
    repeat (11) @(negedge clk);
    for (int m = 0; m < 8; m++) begin
      chk(tag, int'(dac_code), model_code(m + 1, 32'h003F_FFFF, on, a, b, 14'd0), 1);
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R2, R3: vector table, tuning word zero so only offsets matter
    do_reset();
    set_word(0, 32'h0000_0000, 1'b1);
    set_word(1, 32'h0000_1000, 1'b1);
    set_word(2, 32'h0000_2000, 1'b1);
    set_word(3, 32'h0000_3000, 1'b1);
    set_word(4, 32'h0000_3FF0, 1'b1);
    set_word(5, 32'h0000_0800, 1'b1);
    set_word(6, 32'h0000_0000, 1'b0);
    set_word(7, 32'h0000_1004, 1'b1);
    base_pow = 14'h1000;
    base_ftw = '0;
    match_latency = 1'b1;
    for (int v = 0; v < 8; v++) begin
      do_update(VEC[v][12:10]);
      repeat (11) @(negedge clk);
      chk($sformatf("R2/R3 vector %0d", v), int'(dac_code), int'(VEC[v][9:0]), 1);
    end

    // R4: staged inputs without update leave output unchanged
    @(negedge clk);
    prof_sel = 3'd3;
    base_pow = 14'h2000;
    set_word(7, 32'h0000_2000, 1'b1);
    mod_enable = 1'b1;
    mod_step = 32'd1;
    mod_base = 32'd1;
    repeat (15) @(negedge clk);
    chk("R4 no update keeps output", int'(dac_code), 1023, 1);
    mod_enable = 1'b0;
    do_update(3'd3);
    repeat (11) @(negedge clk);
    chk("R4 update applies staged select", int'(dac_code), 0, 1);

    // R7: phase latency, unmatched then matched
    match_latency = 1'b0;
    do_update(3'd0);
    repeat (14) @(negedge clk);
    do_update(3'd3);
    repeat (9) @(negedge clk);
    chk("R7 unmatched edge k+9 old", int'(dac_code), 514, 1);
    @(negedge clk);
    chk("R7 unmatched edge k+10 new", int'(dac_code), 0, 1);
    match_latency = 1'b1;
    do_update(3'd0);
    repeat (14) @(negedge clk);
    do_update(3'd3);
    repeat (10) @(negedge clk);
    chk("R7 matched edge k+10 old", int'(dac_code), 514, 1);
    @(negedge clk);
    chk("R7 matched edge k+11 new", int'(dac_code), 0, 1);

    // R6, R5: frequency latency 11 and quarter-turn accumulation
    do_reset();
    set_word(0, 32'h0000_0000, 1'b1);
    set_word(6, 32'h4000_0000, 1'b0);
    base_pow = '0;
    base_ftw = '0;
    match_latency = 1'b0;
    do_update(3'd0);
    repeat (10) @(negedge clk);
    do_update(3'd6);
    repeat (10) @(negedge clk);
    chk("R6 freq edge k+10 old", int'(dac_code), 514, 1);
    @(negedge clk);
    chk("R6 freq edge k+11 new", int'(dac_code), 1023, 1);
    @(negedge clk);
    chk("R5 second step half turn", int'(dac_code), 509, 1);
    @(negedge clk);
    chk("R5 third step", int'(dac_code), 0, 1);
    repeat (2) @(negedge clk);
    chk("R5 wrap past full turn", int'(dac_code), 1023, 1);

    // R8, R9: fractional modulus stepping
    mod_run("R9 modulus off", 1'b0, 32'd1, 32'd1);
    mod_run("R8 modulus step 1 of 1", 1'b1, 32'd1, 32'd1);
    mod_run("R8 modulus step 2 of 3", 1'b1, 32'd2, 32'd3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule